// File: doc/BRIEF.md
# Tape-machine processor core

This block is a small two-stage processor for a tape-manipulation instruction set. A fetch stage reads one 16-bit instruction per step from a byte-addressed instruction memory. An execute stage works on a data pointer into an external cell memory and on a current-cell register that holds the cell under the pointer. The operations are:

- pointer and cell increment and decrement,
- byte input from an input FIFO and byte output to an output FIFO,
- relative loop jumps measured in bytes,
- no-op, preload and terminate.

A host loads the program and sets `enable`. The core runs from PC 0 until a terminate instruction retires. The host can then read the PC and the sticky status flags. The current cell value is written to cell memory whenever the pointer moves and when the core terminates, so cell memory is up to date for anyone who reads it later.

Top module: `tape_core`

## Requirements
- R1: During reset and after it, `pc` is 0 and `terminated`, `invalid_op` and `wait_input` are low, and no byte is pushed to the output FIFO.
- R2: An instruction is two bytes at an even address. The opcode is bits 7:4 of the byte at the even address, and the byte at the odd address is the jump offset. The PC starts at 0 and advances by 2 per instruction.
- R3: Opcode 0x3 adds 1 to the current cell and 0x4 subtracts 1, both modulo 256. Opcode 0x5 pushes the current cell onto the output FIFO.
- R4: Opcodes 0x1 and 0x2 add or subtract 1 to or from the pointer. Before the pointer moves, the current cell is written to cell memory at the old pointer. The cell register is then reloaded from the new address.
- R5: Opcode 0x7 at address A jumps to A + offset when the current cell is zero. Otherwise execution continues at A + 2.
- R6: Opcode 0x8 at address A jumps to A − offset when the current cell is nonzero. Otherwise execution continues at A + 2.
- R7: Opcode 0x6 with an empty input FIFO stalls the core and raises `wait_input`. Once a byte is present, it is popped into the current cell.
- R8: Opcode 0x5 with a full output FIFO stalls the core without pushing. The push happens once space is available.
- R9: Opcode 0x9 at address A stops execution. `terminated` stays high until reset, `pc` holds A + 2, and the current cell is written to cell memory at the pointer.
- R10: Opcodes 0xB to 0xF set `invalid_op`, which stays high until reset. The instruction otherwise acts as a no-op.
- R11: Opcode 0xA loads the current cell from cell memory at the pointer.
- R12: While `enable` is low, the PC does not change and nothing is pushed or popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run permission; low freezes the core |
| imem_addr | output | 16 | Byte address of the instruction being fetched (always even) |
| imem_rdata | input | 16 | Bits 7:0 are the byte at imem_addr; bits 15:8 are the byte at imem_addr+1 |
| cmem_addr | output | 16 | Cell memory address (the data pointer) |
| cmem_rdata | input | 8 | Cell memory read data, combinational from cmem_addr |
| cmem_we | output | 1 | Cell memory write strobe |
| cmem_wdata | output | 8 | Cell memory write data |
| in_empty | input | 1 | Input FIFO has no data |
| in_data | input | 8 | Head of the input FIFO |
| in_pop | output | 1 | Pops the input FIFO head |
| out_full | input | 1 | Output FIFO cannot accept data |
| out_data | output | 8 | Byte offered to the output FIFO |
| out_push | output | 1 | Pushes out_data |
| pc | output | 16 | Program counter (next fetch address) |
| terminated | output | 1 | Sticky: a terminate instruction has retired |
| invalid_op | output | 1 | Sticky: an undefined opcode was executed |
| wait_input | output | 1 | Core is stalled on an input instruction |

## Verification
The hardest cases to reach from the ports are the loop jumps that meet the fetch pipeline while the cell register is in the middle of a reload. A counted loop is taken backward several times and then exits forward. A separate program skips its body because the cell is zero from the start. The input stall is reached by starting a program whose first instruction reads input while the input FIFO model is empty. The output stall is reached by holding the full flag, and the freeze by dropping `enable` partway through a run. Each of these runs is then compared byte-by-byte against the expected output stream.

// File: rtl/tape_pkg.sv
package tape_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_PINC = 4'h1,
    OP_PDEC = 4'h2,
    OP_CINC = 4'h3,
    OP_CDEC = 4'h4,
    OP_OUT  = 4'h5,
    OP_IN   = 4'h6,
    OP_JFWD = 4'h7,
    OP_JBWD = 4'h8,
    OP_HALT = 4'h9,
    OP_LOAD = 4'hA
  } tape_op_e;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int OFF_W   = 8;

endpackage

// File: rtl/tape_fetch.sv
module tape_fetch
  import tape_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_go,
  input  logic                redirect,
  input  logic [PC_W-1:0]     redirect_pc,
  input  logic                retire,
  input  logic [INSTR_W-1:0]  imem_rdata,
  output logic [PC_W-1:0]     pc,
  output logic                ir_valid,
  output logic [OPC_W-1:0]    ir_op,
  output logic [OFF_W-1:0]    ir_off,
  output logic [PC_W-1:0]     ir_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [PC_W-1:0]  pc_q, pc_d;
  logic             vld_q, vld_d;
  logic [OPC_W-1:0] op_q;
  logic [OFF_W-1:0] off_q;
  logic [PC_W-1:0]  ipc_q;
  logic             ir_load;
  logic             unused_nibble;

  assign unused_nibble = ^imem_rdata[3:0];

  always_comb begin
    pc_d    = pc_q;
    vld_d   = vld_q;
    ir_load = 1'b0;
    if (redirect) begin
      pc_d  = redirect_pc;
      vld_d = 1'b0;
    end else if (fetch_go) begin
      ir_load = 1'b1;
      vld_d   = 1'b1;
      pc_d    = pc_q + STEP;
    end else if (retire) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      vld_q <= 1'b0;
      op_q  <= '0;
      off_q <= '0;
      ipc_q <= '0;
    end else begin
      pc_q  <= pc_d;
      vld_q <= vld_d;
      if (ir_load) begin
        op_q  <= imem_rdata[7:4];
        off_q <= imem_rdata[15:8];
        ipc_q <= pc_q;
      end
    end
  end

  assign pc       = pc_q;
  assign ir_valid = vld_q;
  assign ir_op    = op_q;
  assign ir_off   = off_q;
  assign ir_pc    = ipc_q;

  // R2
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !redirect) |=> (pc_q == $past(pc_q) + STEP));

  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !vld_q);

endmodule

// File: rtl/tape_exec.sv
module tape_exec
  import tape_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PTR_W  = 16,
  parameter int CELL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               ir_valid,
  input  logic [OPC_W-1:0]   ir_op,
  input  logic [OFF_W-1:0]   ir_off,
  input  logic [PC_W-1:0]    ir_pc,
  output logic               retire,
  output logic               redirect,
  output logic [PC_W-1:0]    redirect_pc,
  output logic               halt_now,
  output logic [PTR_W-1:0]   cmem_addr,
  input  logic [CELL_W-1:0]  cmem_rdata,
  output logic               cmem_we,
  output logic [CELL_W-1:0]  cmem_wdata,
  input  logic               in_empty,
  input  logic [CELL_W-1:0]  in_data,
  output logic               in_pop,
  input  logic               out_full,
  output logic [CELL_W-1:0]  out_data,
  output logic               out_push,
  output logic               halted,
  output logic               invalid_op,
  output logic               wait_input
);

  localparam logic [PTR_W-1:0]  PTR_ONE  = PTR_W'(1);
  localparam logic [CELL_W-1:0] CELL_ONE = CELL_W'(1);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CELL_W-1:0] cell_q, cell_d;
  logic              reload_q, reload_d;
  logic              halted_q, halted_d;
  logic              inval_q, inval_d;
  logic              active;
  logic              cell_zero;

  assign active    = enable & ~halted_q;
  assign cell_zero = (cell_q == '0);

  always_comb begin
    ptr_d       = ptr_q;
    cell_d      = cell_q;
    reload_d    = reload_q;
    halted_d    = halted_q;
    inval_d     = inval_q;
    retire      = 1'b0;
    redirect    = 1'b0;
    redirect_pc = ir_pc;
    halt_now    = 1'b0;
    cmem_we     = 1'b0;
    in_pop      = 1'b0;
    out_push    = 1'b0;
    wait_input  = 1'b0;
    if (active) begin
      if (reload_q) begin
        cell_d   = cmem_rdata;
        reload_d = 1'b0;
      end else if (ir_valid) begin
        case (ir_op)
          OP_NOP: retire = 1'b1;
          OP_PINC, OP_PDEC: begin
            retire   = 1'b1;
            cmem_we  = 1'b1;
            reload_d = 1'b1;
            ptr_d    = (ir_op == OP_PINC) ? ptr_q + PTR_ONE : ptr_q - PTR_ONE;
          end
          OP_CINC: begin
            retire = 1'b1;
            cell_d = cell_q + CELL_ONE;
          end
          OP_CDEC: begin
            retire = 1'b1;
            cell_d = cell_q - CELL_ONE;
          end
          OP_OUT: begin
            if (!out_full) begin
              retire   = 1'b1;
              out_push = 1'b1;
            end
          end
          OP_IN: begin
            if (in_empty) begin
              wait_input = 1'b1;
            end else begin
              retire = 1'b1;
              in_pop = 1'b1;
              cell_d = in_data;
            end
          end
          OP_JFWD: begin
            retire      = 1'b1;
            redirect    = cell_zero;
            redirect_pc = ir_pc + PC_W'(ir_off);
          end
          OP_JBWD: begin
            retire      = 1'b1;
            redirect    = ~cell_zero;
            redirect_pc = ir_pc - PC_W'(ir_off);
          end
          OP_HALT: begin
            retire   = 1'b1;
            halt_now = 1'b1;
            halted_d = 1'b1;
            cmem_we  = 1'b1;
          end
          OP_LOAD: begin
            retire = 1'b1;
            cell_d = cmem_rdata;
          end
          default: begin
            retire  = 1'b1;
            inval_d = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      cell_q   <= '0;
      reload_q <= 1'b1;
      halted_q <= 1'b0;
      inval_q  <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      cell_q   <= cell_d;
      reload_q <= reload_d;
      halted_q <= halted_d;
      inval_q  <= inval_d;
    end
  end

  assign cmem_addr  = ptr_q;
  assign cmem_wdata = cell_q;
  assign out_data   = cell_q;
  assign halted     = halted_q;
  assign invalid_op = inval_q;

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q);

  // R10
  invalid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_q |=> inval_q);

  // R4
  ptr_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> $past(cmem_we));

  // R4
  ptr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> !retire);

endmodule

// File: rtl/tape_core.sv
module tape_core
  import tape_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PTR_W  = 16,
  parameter int CELL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [PTR_W-1:0]   cmem_addr,
  input  logic [CELL_W-1:0]  cmem_rdata,
  output logic               cmem_we,
  output logic [CELL_W-1:0]  cmem_wdata,
  input  logic               in_empty,
  input  logic [CELL_W-1:0]  in_data,
  output logic               in_pop,
  input  logic               out_full,
  output logic [CELL_W-1:0]  out_data,
  output logic               out_push,
  output logic [PC_W-1:0]    pc,
  output logic               terminated,
  output logic               invalid_op,
  output logic               wait_input
);

  logic             rst_meta_q, rst_sync_q;
  logic             fetch_go, redirect, retire, halt_now;
  logic [PC_W-1:0]  redirect_pc, ir_pc;
  logic             ir_valid;
  logic [OPC_W-1:0] ir_op;
  logic [OFF_W-1:0] ir_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign fetch_go = enable & ~terminated & ~halt_now & (~ir_valid | retire);

  tape_fetch #(.PC_W(PC_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .fetch_go    (fetch_go),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .retire      (retire),
    .imem_rdata  (imem_rdata),
    .pc          (pc),
    .ir_valid    (ir_valid),
    .ir_op       (ir_op),
    .ir_off      (ir_off),
    .ir_pc       (ir_pc)
  );

  tape_exec #(.PC_W(PC_W), .PTR_W(PTR_W), .CELL_W(CELL_W)) u_exec (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .enable      (enable),
    .ir_valid    (ir_valid),
    .ir_op       (ir_op),
    .ir_off      (ir_off),
    .ir_pc       (ir_pc),
    .retire      (retire),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .halt_now    (halt_now),
    .cmem_addr   (cmem_addr),
    .cmem_rdata  (cmem_rdata),
    .cmem_we     (cmem_we),
    .cmem_wdata  (cmem_wdata),
    .in_empty    (in_empty),
    .in_data     (in_data),
    .in_pop      (in_pop),
    .out_full    (out_full),
    .out_data    (out_data),
    .out_push    (out_push),
    .halted      (terminated),
    .invalid_op  (invalid_op),
    .wait_input  (wait_input)
  );

  assign imem_addr = pc;

  // R12
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !enable |=> $stable(pc));

  // R9
  halt_pc_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    terminated |=> $stable(pc));

endmodule

// File: tb/test_tape_core.sv
`timescale 1ns/1ps
module test_tape_core;

  logic        clk = 1'b0;
  logic        rst_n, enable, cmem_we, in_pop, out_full, out_push;
  logic        terminated, invalid_op, wait_input;
  logic [15:0] imem_addr, imem_rdata, cmem_addr, pc;
  logic [7:0]  cmem_rdata, cmem_wdata, out_data;
  logic        in_empty_r;
  logic [7:0]  in_data_r;

  logic [7:0]  imem [256];
  logic [7:0]  cmem [256];
  logic [7:0]  in_q  [$];
  logic [7:0]  exp_q [$];
  int          checks = 0, errors = 0, pushes = 0, cycles = 0;
  string       cur_req = "R3";

  always #4 clk = ~clk;

  assign imem_rdata = {imem[8'(imem_addr[7:0] + 8'd1)], imem[imem_addr[7:0]]};
  assign cmem_rdata = cmem[cmem_addr[7:0]];

  tape_core i_tape_core (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .cmem_addr(cmem_addr), .cmem_rdata(cmem_rdata), .cmem_we(cmem_we), .cmem_wdata(cmem_wdata),
    .in_empty(in_empty_r), .in_data(in_data_r), .in_pop(in_pop),
    .out_full(out_full), .out_data(out_data), .out_push(out_push),
    .pc(pc), .terminated(terminated), .invalid_op(invalid_op), .wait_input(wait_input)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory and input FIFO models commit at the design's clock edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (cmem_we) cmem[cmem_addr[7:0]] <= cmem_wdata;
      if (in_pop && in_q.size() > 0) void'(in_q.pop_front());
      in_empty_r <= (in_q.size() == 0);
      in_data_r  <= (in_q.size() > 0) ? in_q[0] : 8'h00;
    end
  end

  // monitor: scoreboard compare of output bytes
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
    if (rst_n && out_push) begin
      pushes++;
      if (exp_q.size() == 0) check(1'b0, {cur_req, " unexpected push"}, {24'h0, out_data}, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(out_data == e, {cur_req, " output byte"}, {24'h0, out_data}, {24'h0, e});
      end
    end
  end

  task automatic expect_out(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic put(input int idx, input logic [3:0] op, input logic [7:0] off);
    imem[idx*2]   = {op, 4'h0};
    imem[idx*2+1] = off;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; out_full = 1'b0;
    for (int i = 0; i < 256; i++) begin imem[i] = 8'h00; cmem[i] = 8'h00; end
    in_q.delete(); exp_q.delete(); pushes = 0;
    in_empty_r = 1'b1; in_data_r = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_to_end(input string req);
    int n;
    n = 0;
    enable = 1'b1;
    while (!terminated && n < 3000) begin @(negedge clk); n++; end
    check(terminated == 1'b1, {req, " terminate reached"}, n, 3000);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, {req, " all expected bytes seen"}, exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; out_full = 1'b0;
    in_empty_r = 1'b1; in_data_r = 8'h00;

    // R1 reset state
    do_reset();
    check(pc == 16'h0, "R1 pc", pc, 0);
    check(terminated == 1'b0, "R1 terminated", terminated, 0);
    check(invalid_op == 1'b0, "R1 invalid", invalid_op, 0);
    check(wait_input == 1'b0, "R1 wait", wait_input, 0);
    check(pushes == 0, "R1 no push", pushes, 0);

    // R2 R3 R4 R9: cell arithmetic over two cells
    cur_req = "R3";
    do_reset();
    put(0,4'h3,0); put(1,4'h3,0); put(2,4'h3,0); put(3,4'h5,0);
    put(4,4'h1,0); put(5,4'h3,0); put(6,4'h3,0); put(7,4'h5,0);
    put(8,4'h2,0); put(9,4'h5,0); put(10,4'h9,0);
    expect_out(8'd3); expect_out(8'd2); expect_out(8'd3);
    run_to_end("R3");
    check(pc == 16'd22, "R9 pc after stop", pc, 22);
    check(cmem[1] == 8'd2, "R4 writeback on pointer move", cmem[1], 2);
    check(cmem[0] == 8'd3, "R9 writeback on stop", cmem[0], 3);
    repeat (5) @(negedge clk);
    check(pc == 16'd22 && terminated, "R9 stays stopped", pc, 22);
    check(pushes == 3, "R2 instruction count", pushes, 3);

    // R5 R6: counted loop
    cur_req = "R6";
    do_reset();
    put(0,4'h3,0); put(1,4'h3,0); put(2,4'h3,0);
    put(3,4'h7,8'd8); put(4,4'h5,0); put(5,4'h4,0); put(6,4'h8,8'd4);
    put(7,4'h9,0);
    expect_out(8'd3); expect_out(8'd2); expect_out(8'd1);
    run_to_end("R6");
    check(pc == 16'd16, "R6 loop exit pc", pc, 16);

    // R5: forward skip with zero cell
    cur_req = "R5";
    do_reset();
    put(0,4'h7,8'd4); put(1,4'h5,0); put(2,4'h9,0);
    run_to_end("R5");
    check(pushes == 0, "R5 body skipped", pushes, 0);
    check(pc == 16'd6, "R5 pc", pc, 6);

    // R7: input stall
    cur_req = "R7";
    do_reset();
    put(0,4'h6,0); put(1,4'h5,0); put(2,4'h9,0);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    check(wait_input == 1'b1, "R7 wait raised", wait_input, 1);
    check(pc == 16'd2 && !terminated, "R7 stalled pc", pc, 2);
    in_q.push_back(8'h41);
    expect_out(8'h41);
    run_to_end("R7");
    check(wait_input == 1'b0, "R7 wait cleared", wait_input, 0);
    check(in_q.size() == 0, "R7 byte popped", in_q.size(), 0);

    // R8: output full
    cur_req = "R8";
    do_reset();
    put(0,4'h3,0); put(1,4'h5,0); put(2,4'h9,0);
    out_full = 1'b1;
    enable = 1'b1;
    repeat (20) @(negedge clk);
    check(pushes == 0 && !terminated, "R8 held while full", pushes, 0);
    out_full = 1'b0;
    expect_out(8'd1);
    run_to_end("R8");

    // R10: undefined opcode
    cur_req = "R10";
    do_reset();
    put(0,4'hC,0); put(1,4'h3,0); put(2,4'h5,0); put(3,4'h9,0);
    expect_out(8'd1);
    run_to_end("R10");
    check(invalid_op == 1'b1, "R10 sticky flag", invalid_op, 1);

    // R11: preload restores memory value
    cur_req = "R11";
    do_reset();
    cmem[0] = 8'h7F;
    put(0,4'h3,0); put(1,4'hA,0); put(2,4'h5,0); put(3,4'h9,0);
    expect_out(8'h7F);
    run_to_end("R11");

    // R12: freeze with enable low
    cur_req = "R12";
    do_reset();
    put(0,4'h3,0); put(1,4'h5,0); put(2,4'h3,0); put(3,4'h5,0);
    put(4,4'h3,0); put(5,4'h5,0); put(6,4'h9,0);
    expect_out(8'd1); expect_out(8'd2); expect_out(8'd3);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    begin
      logic [15:0] held_pc;
      int held_push;
      held_pc = pc; held_push = pushes;
      repeat (10) @(negedge clk);
      check(pc == held_pc, "R12 pc frozen", pc, held_pc);
      check(pushes == held_push, "R12 no push while frozen", pushes, held_push);
    end
    run_to_end("R12");

    finish_run();
  end

endmodule